// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

This block is a synchronous dual-port word memory. Its left and right ports are fully independent. Each port has its own address, write data, read data, read/write control, output enable, two byte-lane selects and a pair of chip enables. Either port can read or write any word in any cycle. The two ports can read the same word at the same time.

Each 16-bit word is split into two 8-bit lanes: the upper lane (bits 15:8) and the lower lane (bits 7:0). Each lane has its own active-low select, which applies to both reads and writes. Tri-state drivers are not used. Instead, each port reports one valid flag per lane, and a lane that is not driven reads as zero. Writes take effect on the rising clock edge. Read data and valid flags appear one cycle after the request.

The address width is a parameter. With `ADDR_W` = 16 the memory holds 65536 words. A second parameter, `LEFT_WINS`, fixes which port's data is kept when both ports write the same word in the same cycle.

Top module: `dpr_byte_lane_ram`

## Requirements
- R1: A port is selected only when its active-low chip enable is 0 and its active-high chip enable is 1. Every other combination writes nothing, and the port's valid flags are 00 in the next cycle.
- R2: A selected write (rnw=0, semaphore select high) stores `din` only into the lanes whose select is 0. The other lanes keep their old contents. In the cycle after any write, both valid flags are 00, whatever the output enable is.
- R3: A selected read (rnw=1, oe_n=0, semaphore select high) sets the valid flags one cycle later. Flag bit 1 (upper, data bits 15:8) is 1 exactly when ub_n was 0, and flag bit 0 (lower, data bits 7:0) is 1 exactly when lb_n was 0. Each valid lane carries the stored byte, and each invalid lane reads as 0x00.
- R4: With both lane selects at 1, a selected port writes nothing, and its valid flags are 00.
- R5: With oe_n at 1, a read leaves the valid flags at 00 and the data output at zero.
- R6: With the semaphore select at 0, the port neither writes nor reads the memory, and its valid flags are 00.
- R7: Both ports reading the same address in the same cycle both return the stored word.
- R8: Writes on the two ports in the same cycle, to different addresses, both take effect.
- R9: A read on one port of an address that the other port writes in the same cycle returns the data held before that write.
- R10: During and right after reset, both ports show valid flags 00 and data output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce0_ni | input | 1 | Left chip enable, active low |
| l_ce1_i | input | 1 | Left chip enable, active high |
| l_rnw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_ub_ni | input | 1 | Left upper-lane select, active low |
| l_lb_ni | input | 1 | Left lower-lane select, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low (memory access needs it high) |
| l_addr_i | input | ADDR_W | Left word address |
| l_din_i | input | 16 | Left write data |
| l_dout_o | output | 16 | Left read data, invalid lanes zero |
| l_vld_o | output | 2 | Left lane valid flags {upper, lower} |
| r_ce0_ni | input | 1 | Right chip enable, active low |
| r_ce1_i | input | 1 | Right chip enable, active high |
| r_rnw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_ub_ni | input | 1 | Right upper-lane select, active low |
| r_lb_ni | input | 1 | Right lower-lane select, active low |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_addr_i | input | ADDR_W | Right word address |
| r_din_i | input | 16 | Right write data |
| r_dout_o | output | 16 | Right read data, invalid lanes zero |
| r_vld_o | output | 2 | Right lane valid flags {upper, lower} |

## Verification
The bench runs two sequences of single-lane writes. The read-back after them would show a full-word overwrite, or a swap between the lane masks, if the design got lane masking wrong. Both half-selected chip-enable combinations are tried, as are both lane selects high, output enable high and semaphore select low. A decoder that honoured only one enable, or ignored the semaphore select, would corrupt a stored word that is read back afterwards. The same-cycle write-and-read case across the two ports would return the new data if the read were taken after the write. The simultaneous cross-port writes would lose one word if the two write ports shared a single path.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int LANE_W = 8;
  localparam int NUM_LANES = 2;
  localparam int DATA_W = LANE_W * NUM_LANES;
  localparam int NUM_PORTS = 2;
  typedef logic [NUM_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
  import dpr_pkg::*;
(
  input  logic       ce0_ni,
  input  logic       ce1_i,
  input  logic       rnw_i,
  input  logic       oe_ni,
  input  logic       sem_ni,
  input  lane_mask_t lane_ni,
  output lane_mask_t wr_mask_o,
  output lane_mask_t rd_mask_o
);
  logic sel, ram_acc;

  // both enables must agree; semaphore space bypasses the array
  assign sel     = !ce0_ni && ce1_i;
  assign ram_acc = sel && sem_ni;

  assign wr_mask_o = (ram_acc && !rnw_i)          ? ~lane_ni : '0;
  assign rd_mask_o = (ram_acc && rnw_i && !oe_ni) ? ~lane_ni : '0;
endmodule

// File: rtl/dpr_lane_ram.sv
module dpr_lane_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit LEFT_WINS = 1'b1
) (
  input  logic              clk_i,
  input  logic              we0_i,
  input  logic              we1_i,
  input  logic [ADDR_W-1:0] addr0_i,
  input  logic [ADDR_W-1:0] addr1_i,
  input  logic [LANE_W-1:0] wd0_i,
  input  logic [LANE_W-1:0] wd1_i,
  output logic [LANE_W-1:0] rd0_o,
  output logic [LANE_W-1:0] rd1_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem_q [DEPTH];

  // later nonblocking assignment wins on address collision
  generate
    if (LEFT_WINS) begin : g_left_wins
      always_ff @(posedge clk_i) begin
        if (we1_i) mem_q[addr1_i] <= wd1_i;
        if (we0_i) mem_q[addr0_i] <= wd0_i;
      end
    end else begin : g_right_wins
      always_ff @(posedge clk_i) begin
        if (we0_i) mem_q[addr0_i] <= wd0_i;
        if (we1_i) mem_q[addr1_i] <= wd1_i;
      end
    end
  endgenerate

  // read-before-write: same-cycle writes are not visible
  always_ff @(posedge clk_i) begin
    rd0_o <= mem_q[addr0_i];
    rd1_o <= mem_q[addr1_i];
  end
endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
  import dpr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_mask_t        rd_mask_i,
  input  logic [DATA_W-1:0] raw_i,
  output lane_mask_t        vld_o,
  output logic [DATA_W-1:0] dout_o
);
  lane_mask_t vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= rd_mask_i;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign dout_o[g*LANE_W +: LANE_W] = vld_q[g] ? raw_i[g*LANE_W +: LANE_W] : '0;
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/dpr_byte_lane_ram.sv
module dpr_byte_lane_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit LEFT_WINS = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce0_ni,
  input  logic              l_ce1_i,
  input  logic              l_rnw_i,
  input  logic              l_oe_ni,
  input  logic              l_ub_ni,
  input  logic              l_lb_ni,
  input  logic              l_sem_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [15:0]       l_din_i,
  output logic [15:0]       l_dout_o,
  output logic [1:0]        l_vld_o,
  input  logic              r_ce0_ni,
  input  logic              r_ce1_i,
  input  logic              r_rnw_i,
  input  logic              r_oe_ni,
  input  logic              r_ub_ni,
  input  logic              r_lb_ni,
  input  logic              r_sem_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [15:0]       r_din_i,
  output logic [15:0]       r_dout_o,
  output logic [1:0]        r_vld_o
);
  // index 0 = left, 1 = right
  logic              ce0_n  [NUM_PORTS];
  logic              ce1    [NUM_PORTS];
  logic              rnw    [NUM_PORTS];
  logic              oe_n   [NUM_PORTS];
  logic              sem_n  [NUM_PORTS];
  lane_mask_t        lane_n [NUM_PORTS];
  logic [ADDR_W-1:0] addr   [NUM_PORTS];
  logic [DATA_W-1:0] din    [NUM_PORTS];
  lane_mask_t        wr_m   [NUM_PORTS];
  lane_mask_t        rd_m   [NUM_PORTS];
  logic [DATA_W-1:0] raw    [NUM_PORTS];
  lane_mask_t        vld    [NUM_PORTS];
  logic [DATA_W-1:0] dout   [NUM_PORTS];

  assign ce0_n[0] = l_ce0_ni;  assign ce0_n[1] = r_ce0_ni;
  assign ce1[0]   = l_ce1_i;   assign ce1[1]   = r_ce1_i;
  assign rnw[0]   = l_rnw_i;   assign rnw[1]   = r_rnw_i;
  assign oe_n[0]  = l_oe_ni;   assign oe_n[1]  = r_oe_ni;
  assign sem_n[0] = l_sem_ni;  assign sem_n[1] = r_sem_ni;
  assign lane_n[0] = {l_ub_ni, l_lb_ni};
  assign lane_n[1] = {r_ub_ni, r_lb_ni};
  assign addr[0]  = l_addr_i;  assign addr[1]  = r_addr_i;
  assign din[0]   = l_din_i;   assign din[1]   = r_din_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpr_port_ctl u_ctl (
      .ce0_ni   (ce0_n[p]),
      .ce1_i    (ce1[p]),
      .rnw_i    (rnw[p]),
      .oe_ni    (oe_n[p]),
      .sem_ni   (sem_n[p]),
      .lane_ni  (lane_n[p]),
      .wr_mask_o(wr_m[p]),
      .rd_mask_o(rd_m[p])
    );

    dpr_out_stage u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_mask_i(rd_m[p]),
      .raw_i    (raw[p]),
      .vld_o    (vld[p]),
      .dout_o   (dout[p])
    );
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dpr_lane_ram #(
      .ADDR_W   (ADDR_W),
      .LEFT_WINS(LEFT_WINS)
    ) u_ram (
      .clk_i  (clk_i),
      .we0_i  (wr_m[0][g]),
      .we1_i  (wr_m[1][g]),
      .addr0_i(addr[0]),
      .addr1_i(addr[1]),
      .wd0_i  (din[0][g*LANE_W +: LANE_W]),
      .wd1_i  (din[1][g*LANE_W +: LANE_W]),
      .rd0_o  (raw[0][g*LANE_W +: LANE_W]),
      .rd1_o  (raw[1][g*LANE_W +: LANE_W])
    );
  end

  assign l_dout_o = dout[0];
  assign r_dout_o = dout[1];
  assign l_vld_o  = vld[0];
  assign r_vld_o  = vld[1];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        l_ce0_ni,
  input logic        l_ce1_i,
  input logic        l_rnw_i,
  input logic        l_oe_ni,
  input logic        l_ub_ni,
  input logic        l_lb_ni,
  input logic        l_sem_ni,
  input logic [15:0] l_dout_o,
  input logic [1:0]  l_vld_o,
  input logic        r_ce0_ni,
  input logic        r_ce1_i,
  input logic        r_rnw_i,
  input logic        r_oe_ni,
  input logic        r_ub_ni,
  input logic        r_lb_ni,
  input logic        r_sem_ni,
  input logic [15:0] r_dout_o,
  input logic [1:0]  r_vld_o
);
  AST_L_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce0_ni || !l_ce1_i) |=> (l_vld_o == 2'b00)); // R1
  AST_R_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_ce0_ni || !r_ce1_i) |=> (r_vld_o == 2'b00)); // R1
  AST_L_WR_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rnw_i |=> (l_vld_o == 2'b00)); // R2
  AST_R_WR_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rnw_i |=> (r_vld_o == 2'b00)); // R2
  AST_L_RD_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce0_ni && l_ce1_i && l_rnw_i && !l_oe_ni && l_sem_ni)
    |=> (l_vld_o == ~{$past(l_ub_ni), $past(l_lb_ni)})); // R3
  AST_R_RD_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce0_ni && r_ce1_i && r_rnw_i && !r_oe_ni && r_sem_ni)
    |=> (r_vld_o == ~{$past(r_ub_ni), $past(r_lb_ni)})); // R3
  AST_L_NO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ub_ni && l_lb_ni) |=> (l_vld_o == 2'b00)); // R4
  AST_L_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_oe_ni |=> (l_vld_o == 2'b00 && l_dout_o == 16'h0)); // R5
  AST_R_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_oe_ni |=> (r_vld_o == 2'b00 && r_dout_o == 16'h0)); // R5
  AST_L_SEM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_sem_ni |=> (l_vld_o == 2'b00)); // R6
  AST_R_SEM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_sem_ni |=> (r_vld_o == 2'b00)); // R6
  AST_L_ZERO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_vld_o[1] |-> (l_dout_o[15:8] == 8'h00)); // R3
endmodule

bind dpr_byte_lane_ram dpr_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .l_ce0_ni(l_ce0_ni),
  .l_ce1_i (l_ce1_i),
  .l_rnw_i (l_rnw_i),
  .l_oe_ni (l_oe_ni),
  .l_ub_ni (l_ub_ni),
  .l_lb_ni (l_lb_ni),
  .l_sem_ni(l_sem_ni),
  .l_dout_o(l_dout_o),
  .l_vld_o (l_vld_o),
  .r_ce0_ni(r_ce0_ni),
  .r_ce1_i (r_ce1_i),
  .r_rnw_i (r_rnw_i),
  .r_oe_ni (r_oe_ni),
  .r_ub_ni (r_ub_ni),
  .r_lb_ni (r_lb_ni),
  .r_sem_ni(r_sem_ni),
  .r_dout_o(r_dout_o),
  .r_vld_o (r_vld_o)
);

// File: tb/sim_dpr_byte_lane_ram.sv
`timescale 1ns/1ps
module sim_dpr_byte_lane_ram;
  localparam int AW = 10;

  typedef struct packed {
    logic          ce0n, ce1, rnw, oen, ubn, lbn, semn;
    logic [AW-1:0] addr;
    logic [15:0]   din;
    logic [1:0]    ev;
    logic [15:0]   ed;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 10'd5, 16'h1234, 2'b00, 16'h0000, 4'd2}, // R2 full write
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b11, 16'h1234, 4'd3}, // R3 read both
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 10'd5, 16'hABCD, 2'b00, 16'h0000, 4'd2}, // R2 upper only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b11, 16'hAB34, 4'd2},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 10'd5, 16'h77EF, 2'b00, 16'h0000, 4'd2}, // R2 lower only
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 10'd5, 16'h0000, 2'b10, 16'hAB00, 4'd3}, // R3 upper read
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 10'd5, 16'h0000, 2'b01, 16'h00EF, 4'd3}, // R3 lower read
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 10'd5, 16'hFFFF, 2'b00, 16'h0000, 4'd1}, // R1 ce0 high
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 10'd5, 16'hFFFF, 2'b00, 16'h0000, 4'd1}, // R1 ce1 low
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b11, 16'hABEF, 4'd1},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 10'd5, 16'h0000, 2'b00, 16'h0000, 4'd4}, // R4 no lane write
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 10'd5, 16'h0000, 2'b00, 16'h0000, 4'd4}, // R4 no lane read
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b11, 16'hABEF, 4'd4},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b00, 16'h0000, 4'd5}, // R5 oe high
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 10'd5, 16'h1111, 2'b00, 16'h0000, 4'd6}, // R6 sem write
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 10'd5, 16'h0000, 2'b00, 16'h0000, 4'd6}, // R6 sem read
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b11, 16'hABEF, 4'd6},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd5, 16'h0000, 2'b00, 16'h0000, 4'd1}, // R1 deselected read
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 10'd6, 16'h5A5A, 2'b00, 16'h0000, 4'd2}, // R2 write with oe low
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 10'd6, 16'h0000, 2'b11, 16'h5A5A, 4'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic l_ce0n, l_ce1, l_rnw, l_oen, l_ubn, l_lbn, l_semn;
  logic r_ce0n, r_ce1, r_rnw, r_oen, r_ubn, r_lbn, r_semn;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0]   l_din, r_din, l_dout, r_dout;
  logic [1:0]    l_vld, r_vld;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dpr_byte_lane_ram #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce0_ni(l_ce0n), .l_ce1_i(l_ce1), .l_rnw_i(l_rnw), .l_oe_ni(l_oen),
    .l_ub_ni(l_ubn), .l_lb_ni(l_lbn), .l_sem_ni(l_semn), .l_addr_i(l_addr),
    .l_din_i(l_din), .l_dout_o(l_dout), .l_vld_o(l_vld),
    .r_ce0_ni(r_ce0n), .r_ce1_i(r_ce1), .r_rnw_i(r_rnw), .r_oe_ni(r_oen),
    .r_ub_ni(r_ubn), .r_lb_ni(r_lbn), .r_sem_ni(r_semn), .r_addr_i(r_addr),
    .r_din_i(r_din), .r_dout_o(r_dout), .r_vld_o(r_vld)
  );

  task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drv_l(input logic ce0n, ce1, rnw, oen, ubn, lbn, semn,
                       input logic [AW-1:0] a, input logic [15:0] d);
    {l_ce0n, l_ce1, l_rnw, l_oen, l_ubn, l_lbn, l_semn} = {ce0n, ce1, rnw, oen, ubn, lbn, semn};
    l_addr = a; l_din = d;
  endtask

  task automatic drv_r(input logic ce0n, ce1, rnw, oen, ubn, lbn, semn,
                       input logic [AW-1:0] a, input logic [15:0] d);
    {r_ce0n, r_ce1, r_rnw, r_oen, r_ubn, r_lbn, r_semn} = {ce0n, ce1, rnw, oen, ubn, lbn, semn};
    r_addr = a; r_din = d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    drv_l(1, 0, 1, 1, 1, 1, 1, '0, '0);
    drv_r(1, 0, 1, 1, 1, 1, 1, '0, '0);
    repeat (3) @(negedge clk);
    chk("R10 left in reset", {l_vld, l_dout}, 18'h0);
    chk("R10 right in reset", {r_vld, r_dout}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 left after reset", {l_vld, l_dout}, 18'h0);
    chk("R10 right after reset", {r_vld, r_dout}, 18'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drv_l(TBL[i].ce0n, TBL[i].ce1, TBL[i].rnw, TBL[i].oen, TBL[i].ubn,
            TBL[i].lbn, TBL[i].semn, TBL[i].addr, TBL[i].din);
      @(negedge clk);
      chk($sformatf("R%0d vec %0d", TBL[i].req, i), {l_vld, l_dout}, {TBL[i].ev, TBL[i].ed});
    end

    // R7: both ports read word 5 together
    @(negedge clk);
    drv_l(0, 1, 1, 0, 0, 0, 1, 10'd5, '0);
    drv_r(0, 1, 1, 0, 0, 0, 1, 10'd5, '0);
    @(negedge clk);
    chk("R7 left shared read", {l_vld, l_dout}, {2'b11, 16'hABEF});
    chk("R7 right shared read", {r_vld, r_dout}, {2'b11, 16'hABEF});

    // R8: simultaneous writes, then crossed reads
    drv_l(0, 1, 0, 1, 0, 0, 1, 10'd20, 16'h1111);
    drv_r(0, 1, 0, 1, 0, 0, 1, 10'd21, 16'h2222);
    @(negedge clk);
    drv_l(0, 1, 1, 0, 0, 0, 1, 10'd21, '0);
    drv_r(0, 1, 1, 0, 0, 0, 1, 10'd20, '0);
    @(negedge clk);
    chk("R8 left sees right write", {l_vld, l_dout}, {2'b11, 16'h2222});
    chk("R8 right sees left write", {r_vld, r_dout}, {2'b11, 16'h1111});

    // R9: left writes word 30 while right reads it
    drv_l(0, 1, 0, 1, 0, 0, 1, 10'd30, 16'h3333);
    drv_r(1, 0, 1, 1, 1, 1, 1, '0, '0);
    @(negedge clk);
    drv_l(0, 1, 0, 1, 0, 0, 1, 10'd30, 16'h4444);
    drv_r(0, 1, 1, 0, 0, 0, 1, 10'd30, '0);
    @(negedge clk);
    chk("R9 right read returns old word", {r_vld, r_dout}, {2'b11, 16'h3333});
    drv_l(1, 0, 1, 1, 1, 1, 1, '0, '0);
    @(negedge clk);
    chk("R9 right read after write", {r_vld, r_dout}, {2'b11, 16'h4444});

    // R2 on the right port: upper lane only over a full word
    drv_r(0, 1, 0, 1, 0, 0, 1, 10'd40, 16'h1357);
    @(negedge clk);
    drv_r(0, 1, 0, 1, 0, 1, 1, 10'd40, 16'hC0DE);
    @(negedge clk);
    drv_r(0, 1, 1, 0, 0, 0, 1, 10'd40, '0);
    @(negedge clk);
    chk("R2 right upper-only write", {r_vld, r_dout}, {2'b11, 16'hC057});

    finish_run();
  end
endmodule